// File: doc/BRIEF.md
# Multi-Entry Reservation Register File

This block is the per-processor store of reservations behind a multi-location atomic update. A processor first reserves each location it intends to change: the reserve operation hands the fetched memory word back for a register write and records the line address in a chosen entry. The processor then stages new values into those entries with store-contingent operations. These are purely local and never ask for write ownership. Memory stays untouched until a separate commit controller reads the entries out and writes the staged values back.

While reservations are open, a snoop port watches stores from other agents. A foreign store to any reserved line drops that reservation, so the later commit fails. Compares use cache-line granularity: the offset bits within a line play no part. A clear-all input empties the file once a commit has finished or aborted.

Top module: `resv_file`

## Requirements
- R1: After a synchronous active-low reset, every entry has valid=0 and written=0, and the response valid output is 0.
- R2: A reserve on entry i with address A and memory word W gives, one cycle later, rsp_valid=1 and rsp_data=W. Entry i then holds address A, valid=1, data 0 and written=0.
- R3: A store-contingent with data D on a valid entry sets that entry's data to D and written=1 on the next cycle. Its address and valid bit, and every other entry, are unchanged.
- R4: A store-contingent is ignored in two cases: when it targets an invalid entry, and when it targets the entry being reserved in the same cycle. In both cases the entry's data and written bit end as if it had not been issued.
- R5: A snooped foreign store clears valid on every valid entry whose address matches it in bits [31:6]. The offset bits [5:0] are ignored. Entries on other lines keep valid=1.
- R6: When a snoop invalidation and a store-contingent hit the same entry in one cycle, the entry ends invalid and keeps its previous data and written bit. A snoop whose line equals the line being reserved in that cycle leaves the new entry invalid.
- R7: clear_all sets valid=0 and written=0 on every entry on the next cycle. It overrides a reserve, store-contingent or snoop issued in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rr_valid | input | 1 | Reserve request |
| rr_idx | input | 2 | Entry chosen for the reserve |
| rr_addr | input | 32 | Address being reserved |
| rr_mem_data | input | 32 | Memory word fetched for the reserve |
| rsp_valid | output | 1 | Reserve response valid, one cycle after rr_valid |
| rsp_data | output | 32 | Word returned for the register write |
| sc_valid | input | 1 | Store-contingent request |
| sc_idx | input | 2 | Entry targeted by the store-contingent |
| sc_data | input | 32 | Value staged into the entry |
| snp_valid | input | 1 | A foreign store is observed |
| snp_addr | input | 32 | Address of the foreign store |
| clear_all | input | 1 | Drop every reservation |
| ent_valid | output | 4 | Per-entry reservation valid |
| ent_written | output | 4 | Per-entry data-written flag |
| ent_addr | output | 128 | Entry addresses, entry i in bits [32i+31:32i] |
| ent_data | output | 128 | Entry data, entry i in bits [32i+31:32i] |

## Verification
Two collisions matter most. One is a snoop invalidation landing on an entry in the same cycle as a store-contingent to it. The other is a snoop landing on the line being reserved in that same cycle. Directed steps provoke each collision on purpose, using a snoop address that differs from the entry's address only in the offset bits. Random traffic over a pool of six lines then makes both collisions recur many times. Each cycle the bench model applies the priority order clear, reserve, invalidate, store-contingent, and the full entry state is compared to it.

// File: rtl/resv_pkg.sv
// Shared defaults for the reservation register file.
// Assumes byte addressing and a power-of-two line size.
package resv_pkg;
    localparam int RF_ENTRIES    = 4;
    localparam int RF_ADDR_W     = 32;
    localparam int RF_DATA_W     = 32;
    localparam int RF_LINE_BYTES = 64;
endpackage

// File: rtl/resv_match.sv
// Line-granularity address comparator.
// Compares only the line tag bits; offset bits below OFF_W are ignored.
module resv_match #(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 6
) (
    input  logic [ADDR_W-1:0] addr_a,
    input  logic [ADDR_W-1:0] addr_b,
    output logic              hit
);
    // Tag equality, offset discarded
    always_comb hit = (addr_a[ADDR_W-1:OFF_W] == addr_b[ADDR_W-1:OFF_W]);
endmodule

// File: rtl/resv_entry.sv
// One reservation entry: address, valid, staged data, data-written flag.
// Priority per cycle: clear > reserve > snoop invalidation > store-contingent.
// Assumes the parent gates ld_en and sc_en by index.
module resv_entry #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int OFF_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              ld_en,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic              sc_en,
    input  logic [DATA_W-1:0] sc_data,
    input  logic              snp_valid,
    input  logic [ADDR_W-1:0] snp_addr,
    output logic              valid_q,
    output logic              dirty_q,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] data_q
);
    logic hit_old, hit_new, kill_old, kill_new;

    resv_match #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) i_match_old (
        .addr_a(snp_addr), .addr_b(addr_q), .hit(hit_old));
    resv_match #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) i_match_new (
        .addr_a(snp_addr), .addr_b(ld_addr), .hit(hit_new));

    // Snoop kills: against the stored line, and against a line being reserved now
    always_comb begin
        kill_old = snp_valid && valid_q && hit_old;
        kill_new = snp_valid && hit_new;
    end

    // Entry state update in priority order
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            dirty_q <= 1'b0;
            addr_q  <= '0;
            data_q  <= '0;
        end else if (clr) begin
            valid_q <= 1'b0;
            dirty_q <= 1'b0;
        end else if (ld_en) begin
            addr_q  <= ld_addr;
            data_q  <= '0;
            dirty_q <= 1'b0;
            valid_q <= !kill_new;
        end else if (kill_old) begin
            valid_q <= 1'b0;
        end else if (sc_en && valid_q) begin
            data_q  <= sc_data;
            dirty_q <= 1'b1;
        end
    end

    assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_en && !clr) |=> (data_q == '0) && !dirty_q && (addr_q == $past(ld_addr)));
    assert_stage_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (sc_en && valid_q && !ld_en && !kill_old && !clr) |=> dirty_q && (data_q == $past(sc_data)));
    assert_ignore_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!valid_q && !ld_en && !clr) |=> $stable(data_q) && $stable(dirty_q));
    assert_snoop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_valid && valid_q && hit_old && !ld_en) |=> !valid_q);
    assert_race_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_en && snp_valid && hit_new) |=> !valid_q);
    assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !valid_q && !dirty_q);
endmodule

// File: rtl/resv_file.sv
// Bank of reservation registers for multi-location atomic updates.
// Reserve loads an entry and returns the memory word one cycle later;
// store-contingent stages data locally; snoops drop matching reservations.
// Entry contents are exposed flat for an external commit controller.
module resv_file
    import resv_pkg::*;
#(
    parameter int NUM_ENTRIES = RF_ENTRIES,
    parameter int ADDR_W      = RF_ADDR_W,
    parameter int DATA_W      = RF_DATA_W,
    parameter int LINE_BYTES  = RF_LINE_BYTES,
    localparam int IDX_W      = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1,
    localparam int OFF_W      = $clog2(LINE_BYTES)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          rr_valid,
    input  logic [IDX_W-1:0]              rr_idx,
    input  logic [ADDR_W-1:0]             rr_addr,
    input  logic [DATA_W-1:0]             rr_mem_data,
    output logic                          rsp_valid,
    output logic [DATA_W-1:0]             rsp_data,
    input  logic                          sc_valid,
    input  logic [IDX_W-1:0]              sc_idx,
    input  logic [DATA_W-1:0]             sc_data,
    input  logic                          snp_valid,
    input  logic [ADDR_W-1:0]             snp_addr,
    input  logic                          clear_all,
    output logic [NUM_ENTRIES-1:0]        ent_valid,
    output logic [NUM_ENTRIES-1:0]        ent_written,
    output logic [NUM_ENTRIES*ADDR_W-1:0] ent_addr,
    output logic [NUM_ENTRIES*DATA_W-1:0] ent_data
);
    // Reserve response: hand back the fetched word for the register write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= rr_valid;
            if (rr_valid) rsp_data <= rr_mem_data;
        end
    end

    for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_entry
        logic ld_en, sc_en;
        // Index decode; a reserve to the same entry masks the store-contingent
        always_comb begin
            ld_en = rr_valid && (rr_idx == IDX_W'(g));
            sc_en = sc_valid && (sc_idx == IDX_W'(g)) && !ld_en;
        end

        resv_entry #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFF_W(OFF_W)) i_entry (
            .clk      (clk),
            .rst_n    (rst_n),
            .clr      (clear_all),
            .ld_en    (ld_en),
            .ld_addr  (rr_addr),
            .sc_en    (sc_en),
            .sc_data  (sc_data),
            .snp_valid(snp_valid),
            .snp_addr (snp_addr),
            .valid_q  (ent_valid[g]),
            .dirty_q  (ent_written[g]),
            .addr_q   (ent_addr[g*ADDR_W +: ADDR_W]),
            .data_q   (ent_data[g*DATA_W +: DATA_W])
        );
    end

    assert_rsp_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rr_valid |=> rsp_valid && (rsp_data == $past(rr_mem_data)));
    assert_rsp_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !rr_valid |=> !rsp_valid);
endmodule

// File: tb/test_resv_file.sv
// Self-checking bench: directed corner cases, then seeded random traffic
// against a reference model built from the requirements.
module test_resv_file;
    localparam int N = 4;
    localparam int AW = 32;
    localparam int DW = 32;

    logic clk = 1'b0;
    logic rst_n;
    logic rr_valid; logic [1:0] rr_idx; logic [AW-1:0] rr_addr; logic [DW-1:0] rr_mem_data;
    logic rsp_valid; logic [DW-1:0] rsp_data;
    logic sc_valid; logic [1:0] sc_idx; logic [DW-1:0] sc_data;
    logic snp_valid; logic [AW-1:0] snp_addr;
    logic clear_all;
    logic [N-1:0] ent_valid, ent_written;
    logic [N*AW-1:0] ent_addr;
    logic [N*DW-1:0] ent_data;

    int errors = 0;
    int checks = 0;

    // reference model state
    logic          m_v [N];
    logic          m_w [N];
    logic [AW-1:0] m_a [N];
    logic [DW-1:0] m_d [N];
    logic          m_rv;
    logic [DW-1:0] m_rd;

    always #5 clk = ~clk;

    resv_file i_resv_file (
        .clk(clk), .rst_n(rst_n),
        .rr_valid(rr_valid), .rr_idx(rr_idx), .rr_addr(rr_addr), .rr_mem_data(rr_mem_data),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .sc_valid(sc_valid), .sc_idx(sc_idx), .sc_data(sc_data),
        .snp_valid(snp_valid), .snp_addr(snp_addr), .clear_all(clear_all),
        .ent_valid(ent_valid), .ent_written(ent_written),
        .ent_addr(ent_addr), .ent_data(ent_data));

    function automatic logic same_line(logic [AW-1:0] a, logic [AW-1:0] b);
        return a[AW-1:6] == b[AW-1:6];
    endfunction

    task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic compare_all(string tag);
        chk(tag, "rsp_valid", 64'(rsp_valid), 64'(m_rv));
        if (m_rv) chk(tag, "rsp_data", 64'(rsp_data), 64'(m_rd));
        for (int e = 0; e < N; e++) begin
            chk(tag, $sformatf("valid[%0d]", e), 64'(ent_valid[e]), 64'(m_v[e]));
            chk(tag, $sformatf("written[%0d]", e), 64'(ent_written[e]), 64'(m_w[e]));
            chk(tag, $sformatf("addr[%0d]", e), 64'(ent_addr[e*AW +: AW]), 64'(m_a[e]));
            chk(tag, $sformatf("data[%0d]", e), 64'(ent_data[e*DW +: DW]), 64'(m_d[e]));
        end
    endtask

    task automatic model_step();
        m_rv = rr_valid;
        if (rr_valid) m_rd = rr_mem_data;
        for (int e = 0; e < N; e++) begin
            if (clear_all) begin
                m_v[e] = 1'b0; m_w[e] = 1'b0;
            end else if (rr_valid && rr_idx == e[1:0]) begin
                m_a[e] = rr_addr; m_d[e] = '0; m_w[e] = 1'b0;
                m_v[e] = !(snp_valid && same_line(snp_addr, rr_addr));
            end else if (snp_valid && m_v[e] && same_line(snp_addr, m_a[e])) begin
                m_v[e] = 1'b0;
            end else if (sc_valid && sc_idx == e[1:0] && m_v[e]) begin
                m_d[e] = sc_data; m_w[e] = 1'b1;
            end
        end
    endtask

    task automatic idle_inputs();
        rr_valid = 0; rr_idx = 0; rr_addr = 0; rr_mem_data = 0;
        sc_valid = 0; sc_idx = 0; sc_data = 0;
        snp_valid = 0; snp_addr = 0; clear_all = 0;
    endtask

    // one clock: model predicts, design clocks, compare after the edge
    task automatic step(string tag);
        model_step();
        @(posedge clk); #1;
        compare_all(tag);
        idle_inputs();
    endtask

    task automatic do_rr(int idx, logic [AW-1:0] a, logic [DW-1:0] w);
        rr_valid = 1; rr_idx = 2'(idx); rr_addr = a; rr_mem_data = w;
    endtask
    task automatic do_sc(int idx, logic [DW-1:0] d);
        sc_valid = 1; sc_idx = 2'(idx); sc_data = d;
    endtask
    task automatic do_snp(logic [AW-1:0] a);
        snp_valid = 1; snp_addr = a;
    endtask

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd20080528));
        idle_inputs();
        rst_n = 0;
        for (int e = 0; e < N; e++) begin
            m_v[e] = 0; m_w[e] = 0; m_a[e] = 0; m_d[e] = 0;
        end
        m_rv = 0; m_rd = 0;
        repeat (3) @(posedge clk);
        #1;
        compare_all("R1");
        rst_n = 1;
        step("R1");

        // R2: reserve returns the word and records the line
        do_rr(1, 32'h1000_0044, 32'hCAFE_0001);
        step("R2");
        // R3: stage data into a valid entry
        do_sc(1, 32'h0000_0055);
        step("R3");
        // R4: store-contingent to an invalid entry is dropped
        do_sc(2, 32'hDEAD_BEEF);
        step("R4");
        // R4: store-contingent to the entry being reserved is dropped
        do_rr(0, 32'h3000_0000, 32'h1111_2222); do_sc(0, 32'h7777_7777);
        step("R4");
        // R5: snoop with different offset on the same line kills the entry
        do_rr(2, 32'h2000_0080, 32'h0BAD_F00D);
        step("R2");
        do_snp(32'h2000_00BF);
        step("R5");
        // R5: snoop on a neighbouring line leaves entry 1 alone
        do_snp(32'h1000_0080);
        step("R5");
        // R6: snoop and store-contingent on the same entry
        do_sc(1, 32'h9999_0000); do_snp(32'h1000_0040);
        step("R6");
        // R6: snoop on the line being reserved
        do_rr(3, 32'h4000_0100, 32'h4444_4444); do_snp(32'h4000_013C);
        step("R6");
        // R7: clear overrides a reserve and a store-contingent
        do_rr(1, 32'h5000_0000, 32'h5555_5555); do_sc(0, 32'h1234_5678); clear_all = 1;
        step("R7");

        // random traffic over six lines
        for (int i = 0; i < 4000; i++) begin
            logic [AW-1:0] base_a, base_s;
            base_a = 32'h8000_0000 + ({26'($urandom_range(0, 5)), 6'b0});
            base_s = 32'h8000_0000 + ({26'($urandom_range(0, 5)), 6'b0});
            if ($urandom_range(0, 3) == 0)
                do_rr($urandom_range(0, 3), base_a | 32'($urandom_range(0, 63)), $urandom);
            if ($urandom_range(0, 1) == 0)
                do_sc($urandom_range(0, 3), $urandom);
            if ($urandom_range(0, 4) == 0)
                do_snp(base_s | 32'($urandom_range(0, 63)));
            if ($urandom_range(0, 39) == 0) clear_all = 1;
            step("R3/R5/R6 random");
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule